// File: doc/BRIEF.md
# NAND Flash Host Register Front End

This block sits between a register bus and an 8-bit NAND flash device. Software programs strobe timing in a control register, then pushes command, address and data bytes by writing dedicated registers. Each of these writes becomes one entry in a small in-order queue. A bus sequencer drains the queue and turns each entry into a single flash bus cycle. Command bytes go out with the command latch asserted and address bytes with the address latch asserted. Write-enable or read-enable low pulses have programmable widths, and every pulse is followed by a fixed recovery time.

Reads take two steps. Writing any value to the read-request register queues one read strobe. When the byte has been latched, it is placed in a read buffer register and a sticky ready flag is raised. Software clears that flag by writing one to it. A separate status register reports the synchronised ready/busy pin, queue fullness and emptiness, and pending page writes and reads. An interrupt status register collects events, and the interrupt output is the OR of those events that are enabled in a mask register. A self-clearing reset register models the clear handshake of an error-code accumulator.

Top module: `nand_host_frontend`

## Requirements
- R1: After reset the status register reads 0x11 (bit 0 not-busy with the ready pin high, bit 4 queue empty), the interrupt status reads 0, both strobes are high, both latches are low and `irq` is low.
- R2: The control register at offset 0 holds the write-strobe delay in bits [3:0], the read-strobe delay in bits [7:4], the bus-width select in bit 8 and the page-size select in bit 9 (1 = 512-byte pages), and reads back exactly what was written.
- R3: A write to offset 4 (command) produces one bus cycle with the command latch high and the address latch low. A write to offset 5 (address) produces one with the address latch high and the command latch low. Offset 6 (data) produces one with both latches low. In each case the payload is driven with output enable high and write-enable low for (write delay + 1) cycles.
- R4: Every strobe low pulse is followed by exactly 2 cycles with both strobes high before the next pulse when more work is queued, and queued entries appear on the bus strictly in the order written.
- R5: A write of any value to offset 7 queues a read cycle with read-enable low for (read delay + 1) cycles and output enable low. The byte on `nf_dq_in` during the last low cycle appears at offset 8, and interrupt status bit 3 is set.
- R6: The queue holds 4 entries. Status bit 1 reads 1 while it is full. A queue write made while it is full is dropped and sets interrupt status bit 1.
- R7: Interrupt status (offset 2) bits stay set until a write to offset 2 carries a 1 in that bit. Zero bits in such a write leave the corresponding status bits unchanged.
- R8: `irq` is high exactly when some interrupt status bit is set whose bit in the mask register (offset 3) is also set.
- R9: Status bit 0 follows `nf_rdy` through a two-stage synchroniser, and a low-to-high change of the synchronised value sets interrupt status bit 0.
- R10: Status bit 4 reads 1 while the queue is empty, and the queue going from non-empty to empty sets interrupt status bit 2.
- R11: Status bit 2 reads 1 while a data-write entry is queued or on the bus, and status bit 3 reads 1 while a read request is queued or on the bus. The completion of the last outstanding data-write cycle sets interrupt status bit 4.
- R12: Writing 1 to bit 0 of offset 9 makes that bit read 1 for exactly 4 cycles (the default `CLR_CYCLES`), after which it reads 0 on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data (combinational from offset) |
| irq | output | 1 | Masked interrupt request |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_dq_out | output | 8 | Flash data bus, outbound |
| nf_dq_oe | output | 1 | Drive enable for nf_dq_out |
| nf_dq_in | input | 8 | Flash data bus, inbound |
| nf_rdy | input | 1 | Flash ready/busy pin, high = ready |

## Verification
A register write takes effect at the clock edge where it is sampled, so the bench reads registers and the combinational `irq` on the falling edge after that edge. The queue entry is popped on the next edge, so the strobe falls two edges after the write. It then stays low for delay + 1 cycles and high for 2. The read byte and its ready flag become valid on the edge that ends the last low cycle. Pin changes reach the status register after two edges. The bench measures strobe widths and recovery gaps on every falling edge from the pins. It waits long enough for the queue to drain before comparing the recorded cycles, and it counts the self-clearing reset bit cycle by cycle.

// File: rtl/nfh_pkg.sv
package nfh_pkg;
    localparam int unsigned DLY_W    = 4;
    localparam int unsigned REG_W    = 10;
    localparam int unsigned IRQ_N    = 5;
    localparam int unsigned HIGH_CYC = 2;

    localparam logic [3:0] OFF_CTRL   = 4'd0;
    localparam logic [3:0] OFF_STAT   = 4'd1;
    localparam logic [3:0] OFF_IRQ    = 4'd2;
    localparam logic [3:0] OFF_MASK   = 4'd3;
    localparam logic [3:0] OFF_CMD    = 4'd4;
    localparam logic [3:0] OFF_ADDR   = 4'd5;
    localparam logic [3:0] OFF_DWR    = 4'd6;
    localparam logic [3:0] OFF_DRD    = 4'd7;
    localparam logic [3:0] OFF_RDBUF  = 4'd8;
    localparam logic [3:0] OFF_ECCRST = 4'd9;

    localparam int IRQ_NOTBUSY = 0;
    localparam int IRQ_OVF     = 1;
    localparam int IRQ_EDGE    = 2;
    localparam int IRQ_RDRDY   = 3;
    localparam int IRQ_WRDONE  = 4;

    typedef enum logic [1:0] {
        ENT_CMD  = 2'd0,
        ENT_ADDR = 2'd1,
        ENT_DWR  = 2'd2,
        ENT_RREQ = 2'd3
    } ent_kind_e;

    typedef struct packed {
        ent_kind_e  kind;
        logic [7:0] payload;
    } bus_ent_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOW  = 2'd1,
        SEQ_HIGH = 2'd2
    } seq_state_e;

    function automatic logic is_queue_off(input logic [3:0] off);
        return (off == OFF_CMD) || (off == OFF_ADDR) ||
               (off == OFF_DWR) || (off == OFF_DRD);
    endfunction

    function automatic ent_kind_e kind_of(input logic [3:0] off);
        case (off)
            OFF_CMD:  return ENT_CMD;
            OFF_ADDR: return ENT_ADDR;
            OFF_DWR:  return ENT_DWR;
            default:  return ENT_RREQ;
        endcase
    endfunction
endpackage

// File: rtl/nfh_fifo.sv
module nfh_fifo
    import nfh_pkg::*;
#(
    parameter int unsigned DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  bus_ent_t push_ent,
    input  logic     pop,
    output bus_ent_t head,
    output logic     empty,
    output logic     full,
    output logic     drained
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    bus_ent_t        mem [DEPTH];
    logic [PW-1:0]   wr_ptr, rd_ptr;
    logic [CW-1:0]   count;
    logic            do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drained = do_pop && !do_push && (count == CW'(1));
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/nfh_bus_seq.sv
module nfh_bus_seq
    import nfh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ent_valid,
    input  bus_ent_t         ent,
    input  logic [DLY_W-1:0] wr_dly,
    input  logic [DLY_W-1:0] rd_dly,
    input  logic [7:0]       dq_in,
    output logic             pop,
    output logic             cle,
    output logic             ale,
    output logic             we_n,
    output logic             re_n,
    output logic [7:0]       dq_out,
    output logic             dq_oe,
    output logic             cap_valid,
    output logic [7:0]       cap_byte,
    output logic             dwr_retire
);
    seq_state_e       state;
    bus_ent_t         cur;
    logic [DLY_W-1:0] cnt;
    logic             start, active, is_read;

    assign active  = (state != SEQ_IDLE);
    assign is_read = (cur.kind == ENT_RREQ);

    always_comb begin
        start = 1'b0;
        if (state == SEQ_IDLE) start = ent_valid;
        else if (state == SEQ_HIGH && cnt == '0) start = ent_valid;
    end
    assign pop = start;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            cnt   <= '0;
            cur   <= '0;
        end else begin
            if (start) begin
                cur   <= ent;
                cnt   <= (ent.kind == ENT_RREQ) ? rd_dly : wr_dly;
                state <= SEQ_LOW;
            end else begin
                case (state)
                    SEQ_LOW: begin
                        if (cnt == '0) begin
                            state <= SEQ_HIGH;
                            cnt   <= DLY_W'(HIGH_CYC - 1);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    SEQ_HIGH: begin
                        if (cnt == '0) state <= SEQ_IDLE;
                        else           cnt   <= cnt - 1'b1;
                    end
                    default: state <= SEQ_IDLE;
                endcase
            end
        end
    end

    assign cle        = active && (cur.kind == ENT_CMD);
    assign ale        = active && (cur.kind == ENT_ADDR);
    assign we_n       = !((state == SEQ_LOW) && !is_read);
    assign re_n       = !((state == SEQ_LOW) && is_read);
    assign dq_oe      = active && !is_read;
    assign dq_out     = cur.payload;
    assign cap_valid  = (state == SEQ_LOW) && (cnt == '0) && is_read;
    assign cap_byte   = dq_in;
    assign dwr_retire = (state == SEQ_HIGH) && (cnt == '0) && (cur.kind == ENT_DWR);
endmodule

// File: rtl/nfh_irq.sv
module nfh_irq #(
    parameter int unsigned N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] stat,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)                         stat[i] <= 1'b0;
            else if (set_ev[i])              stat[i] <= 1'b1;
            else if (clr_we && clr_bits[i])  stat[i] <= 1'b0;
        end
    end

    assign irq = |(stat & mask);
endmodule

// File: rtl/nand_host_frontend.sv
module nand_host_frontend
    import nfh_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned CLR_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       reg_addr,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic [7:0]       nf_dq_out,
    output logic             nf_dq_oe,
    input  logic [7:0]       nf_dq_in,
    input  logic             nf_rdy
);
    localparam int unsigned PCW  = $clog2(FIFO_DEPTH + 2);
    localparam int unsigned CLRW = $clog2(CLR_CYCLES + 1);

    logic [REG_W-1:0] ctrl_q;
    logic [IRQ_N-1:0] mask_q, irq_stat, irq_set;
    logic [7:0]       rdbuf_q;
    logic             rdy_s1, rdy_s2, rdy_d;
    logic [PCW-1:0]   dw_pend, rd_pend;
    logic             ecc_busy;
    logic [CLRW-1:0]  ecc_cnt;

    logic     q_wr, push, ovf_ev;
    bus_ent_t push_ent, head;
    logic     fifo_empty, fifo_full, fifo_drained, pop;
    logic     cap_valid, dwr_retire;
    logic [7:0] cap_byte;
    logic     dw_inc, rd_inc, wr_done_ev;

    assign q_wr     = reg_we && is_queue_off(reg_addr);
    assign push     = q_wr && !fifo_full;
    assign ovf_ev   = q_wr && fifo_full;
    assign push_ent = '{kind: kind_of(reg_addr), payload: reg_wdata[7:0]};

    nfh_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_ent(push_ent), .pop(pop),
        .head(head), .empty(fifo_empty), .full(fifo_full), .drained(fifo_drained)
    );

    nfh_bus_seq u_seq (
        .clk(clk), .rst(rst), .ent_valid(!fifo_empty), .ent(head),
        .wr_dly(ctrl_q[3:0]), .rd_dly(ctrl_q[7:4]), .dq_in(nf_dq_in),
        .pop(pop), .cle(nf_cle), .ale(nf_ale), .we_n(nf_we_n), .re_n(nf_re_n),
        .dq_out(nf_dq_out), .dq_oe(nf_dq_oe), .cap_valid(cap_valid),
        .cap_byte(cap_byte), .dwr_retire(dwr_retire)
    );

    // configuration and mask registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == OFF_CTRL) ctrl_q <= reg_wdata;
            if (reg_addr == OFF_MASK) mask_q <= reg_wdata[IRQ_N-1:0];
        end
    end

    // captured read byte
    always_ff @(posedge clk) begin
        if (rst)            rdbuf_q <= '0;
        else if (cap_valid) rdbuf_q <= cap_byte;
    end

    // ready/busy pin synchroniser, idle value is "ready"
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_s1 <= 1'b1;
            rdy_s2 <= 1'b1;
            rdy_d  <= 1'b1;
        end else begin
            rdy_s1 <= nf_rdy;
            rdy_s2 <= rdy_s1;
            rdy_d  <= rdy_s2;
        end
    end

    // outstanding page write / read tracking
    assign dw_inc     = push && (push_ent.kind == ENT_DWR);
    assign rd_inc     = push && (push_ent.kind == ENT_RREQ);
    assign wr_done_ev = dwr_retire && !dw_inc && (dw_pend == PCW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            dw_pend <= '0;
            rd_pend <= '0;
        end else begin
            case ({dw_inc, dwr_retire})
                2'b10:   dw_pend <= dw_pend + 1'b1;
                2'b01:   dw_pend <= dw_pend - 1'b1;
                default: dw_pend <= dw_pend;
            endcase
            case ({rd_inc, cap_valid})
                2'b10:   rd_pend <= rd_pend + 1'b1;
                2'b01:   rd_pend <= rd_pend - 1'b1;
                default: rd_pend <= rd_pend;
            endcase
        end
    end

    // self-clearing accumulator reset handshake
    always_ff @(posedge clk) begin
        if (rst) begin
            ecc_busy <= 1'b0;
            ecc_cnt  <= '0;
        end else if (reg_we && reg_addr == OFF_ECCRST && reg_wdata[0]) begin
            ecc_busy <= 1'b1;
            ecc_cnt  <= CLRW'(CLR_CYCLES - 1);
        end else if (ecc_busy) begin
            if (ecc_cnt == '0) ecc_busy <= 1'b0;
            else               ecc_cnt  <= ecc_cnt - 1'b1;
        end
    end

    always_comb begin
        irq_set              = '0;
        irq_set[IRQ_NOTBUSY] = rdy_s2 && !rdy_d;
        irq_set[IRQ_OVF]     = ovf_ev;
        irq_set[IRQ_EDGE]    = fifo_drained;
        irq_set[IRQ_RDRDY]   = cap_valid;
        irq_set[IRQ_WRDONE]  = wr_done_ev;
    end

    nfh_irq #(.N(IRQ_N)) u_irq (
        .clk(clk), .rst(rst), .set_ev(irq_set),
        .clr_we(reg_we && reg_addr == OFF_IRQ), .clr_bits(reg_wdata[IRQ_N-1:0]),
        .mask(mask_q), .stat(irq_stat), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL:   reg_rdata = ctrl_q;
            OFF_STAT:   reg_rdata = REG_W'({fifo_empty, rd_pend != '0, dw_pend != '0,
                                            fifo_full, rdy_s2});
            OFF_IRQ:    reg_rdata = REG_W'(irq_stat);
            OFF_MASK:   reg_rdata = REG_W'(mask_q);
            OFF_RDBUF:  reg_rdata = REG_W'(rdbuf_q);
            OFF_ECCRST: reg_rdata = REG_W'(ecc_busy);
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nfh_checker.sv
module nfh_checker
    import nfh_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             we_n,
    input logic             re_n,
    input logic             cle,
    input logic             ale,
    input logic             dq_oe,
    input logic             irq,
    input logic             reg_we,
    input logic [3:0]       reg_addr,
    input logic             wdata_rdy_bit,
    input logic [IRQ_N-1:0] irq_stat,
    input logic             fifo_full
);
    // R3: never both strobes low at once
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(!we_n && !re_n));

    // R3: latches are mutually exclusive
    assert_latch_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(cle && ale));

    // R5: no outbound drive during a read strobe
    assert_read_no_drive_R5: assert property (@(posedge clk) disable iff (rst)
        !re_n |-> !dq_oe);

    // R4: a strobe release is followed by a recovery cycle
    assert_recovery_we_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |=> (we_n && re_n));
    assert_recovery_re_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(re_n) |=> (we_n && re_n));

    // R6: queue write while full flags overflow
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_we && is_queue_off(reg_addr) && fifo_full) |=> irq_stat[IRQ_OVF]);

    // R7: read-ready flag is sticky until written with one
    assert_rdy_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_stat[IRQ_RDRDY] && !(reg_we && reg_addr == OFF_IRQ && wdata_rdy_bit))
        |=> irq_stat[IRQ_RDRDY]);

    // R8: no request without a pending event
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (irq_stat != '0));
endmodule

bind nand_host_frontend nfh_checker u_chk (
    .clk(clk), .rst(rst), .we_n(nf_we_n), .re_n(nf_re_n), .cle(nf_cle), .ale(nf_ale),
    .dq_oe(nf_dq_oe), .irq(irq), .reg_we(reg_we), .reg_addr(reg_addr),
    .wdata_rdy_bit(reg_wdata[3]), .irq_stat(irq_stat), .fifo_full(fifo_full)
);

// File: tb/nand_host_frontend_test.sv
module nand_host_frontend_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [9:0] reg_wdata = '0;
    logic [9:0] reg_rdata;
    logic       irq, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0] nf_dq_out;
    logic [7:0] nf_dq_in = '0;
    logic       nf_rdy = 1'b1;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    nand_host_frontend uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n),
        .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rdy(nf_rdy)
    );

    // bus monitor: records each strobe pulse
    int         lg_n = 0;
    int         lg_w [32];
    int         lg_gap [32];
    logic [7:0] lg_dq [32];
    logic       lg_cle [32], lg_ale [32], lg_rd [32], lg_oe [32];
    int         lowcnt = 0, gapcnt = 0, cur_gap = 0;
    bit         in_low = 1'b0;
    logic       c_cle, c_ale, c_rd, c_oe;
    logic [7:0] c_dq;

    always @(negedge clk) begin
        if (rst) begin
            in_low = 1'b0; lowcnt = 0; gapcnt = 0;
        end else if (!nf_we_n || !nf_re_n) begin
            if (!in_low) begin
                in_low = 1'b1; lowcnt = 0; cur_gap = gapcnt;
                c_cle = nf_cle; c_ale = nf_ale; c_rd = !nf_re_n;
                c_oe = nf_dq_oe; c_dq = nf_dq_out;
            end
            lowcnt++;
        end else begin
            if (in_low) begin
                if (lg_n < 32) begin
                    lg_w[lg_n] = lowcnt; lg_gap[lg_n] = cur_gap; lg_dq[lg_n] = c_dq;
                    lg_cle[lg_n] = c_cle; lg_ale[lg_n] = c_ale;
                    lg_rd[lg_n] = c_rd; lg_oe[lg_n] = c_oe;
                end
                lg_n++;
                in_low = 1'b0; gapcnt = 0;
            end
            gapcnt++;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [9:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [9:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle();
        repeat (120) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [9:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(4'd1, v); chk("R1", "status", v, 10'h011);
        rd(4'd2, v); chk("R1", "irq status", v, 10'h000);
        chk("R1", "strobes/latches/irq", {nf_we_n, nf_re_n, nf_cle, nf_ale, irq}, 5'b11000);

        // R2 control readback
        wr(4'd0, 10'h3A5); rd(4'd0, v); chk("R2", "ctrl readback", v, 10'h3A5);
        wr(4'd0, 10'h25A); rd(4'd0, v); chk("R2", "ctrl readback", v, 10'h25A);

        // R3/R4 sweep write delay over all values: command then address then data
        for (int d = 0; d < 16; d++) begin
            wr(4'd0, 10'(d));
            wr(4'd2, 10'h01F);
            lg_n = 0;
            wr(4'd4, 10'(8'h80 + d));
            wr(4'd5, 10'(8'h40 + d));
            wr(4'd6, 10'(8'hC3 ^ d));
            settle();
            chk("R3", "cycle count", lg_n, 3);
            chk("R3", "cmd latches/rd/oe", {lg_cle[0], lg_ale[0], lg_rd[0], lg_oe[0]}, 4'b1001);
            chk("R3", "cmd byte", lg_dq[0], 8'h80 + d);
            chk("R3", "cmd width", lg_w[0], d + 1);
            chk("R3", "addr latches/rd/oe", {lg_cle[1], lg_ale[1], lg_rd[1], lg_oe[1]}, 4'b0101);
            chk("R3", "addr byte", lg_dq[1], 8'h40 + d);
            chk("R3", "data latches/rd/oe", {lg_cle[2], lg_ale[2], lg_rd[2], lg_oe[2]}, 4'b0001);
            chk("R3", "data byte", lg_dq[2], 8'hC3 ^ d);
            chk("R3", "data width", lg_w[2], d + 1);
            chk("R4", "recovery gap 1", lg_gap[1], 2);
            chk("R4", "recovery gap 2", lg_gap[2], 2);
            rd(4'd2, v); chk("R11", "page write done flag", v[4], 1'b1);
            chk("R10", "drain edge flag", v[2], 1'b1);
        end

        // R5 sweep read delay
        for (int d = 0; d < 16; d++) begin
            wr(4'd0, 10'(d << 4));
            wr(4'd2, 10'h01F);
            lg_n = 0;
            nf_dq_in = 8'(8'h5A + d * 17);
            wr(4'd7, 10'h3FF);
            if (d == 15) begin
                rd(4'd1, v); chk("R11", "read pending status", v, 10'h009);
            end
            settle();
            chk("R5", "read cycle count", lg_n, 1);
            chk("R5", "read latches/rd/oe", {lg_cle[0], lg_ale[0], lg_rd[0], lg_oe[0]}, 4'b0010);
            chk("R5", "read width", lg_w[0], d + 1);
            rd(4'd8, v); chk("R5", "read buffer", v, 10'(8'(8'h5A + d * 17)));
            rd(4'd2, v); chk("R5", "read ready flag", v[3], 1'b1);
            wr(4'd2, 10'h000); rd(4'd2, v); chk("R7", "zero write keeps flag", v[3], 1'b1);
            wr(4'd2, 10'h008); rd(4'd2, v); chk("R7", "w1c clears flag", v[3], 1'b0);
            chk("R7", "other flags kept", v[2], 1'b1);
        end

        // R6 overflow: slow strobes, six queued writes, one dropped
        wr(4'd0, 10'h00F);
        wr(4'd2, 10'h01F);
        lg_n = 0;
        for (int i = 0; i < 5; i++) wr(4'd6, 10'(8'h10 + i));
        rd(4'd1, v); chk("R6", "full + write pending status", v, 10'h007);
        wr(4'd6, 10'h0EE);
        rd(4'd2, v); chk("R6", "overflow flag", v[1], 1'b1);
        settle();
        chk("R6", "accepted cycles", lg_n, 5);
        for (int i = 0; i < 5; i++) chk("R4", "order", lg_dq[i], 8'h10 + i);
        rd(4'd1, v); chk("R10", "idle status empty", v, 10'h011);
        rd(4'd2, v); chk("R11", "irq status after drain", v, 10'h016);

        // R8 mask sweep against irq status 0x16
        for (int b = 0; b < 5; b++) begin
            wr(4'd3, 10'(1 << b));
            chk("R8", "masked irq", irq, (10'h016 >> b) & 1);
        end
        wr(4'd3, 10'h000); chk("R8", "all masked", irq, 1'b0);
        wr(4'd3, 10'h01F); chk("R8", "all enabled", irq, 1'b1);
        wr(4'd2, 10'h01F); chk("R8", "cleared", irq, 1'b0);

        // R9 ready/busy tracking
        @(negedge clk); nf_rdy = 1'b0;
        repeat (4) @(negedge clk);
        rd(4'd1, v); chk("R9", "busy seen", v[0], 1'b0);
        rd(4'd2, v); chk("R9", "no event on fall", v[0], 1'b0);
        nf_rdy = 1'b1;
        repeat (4) @(negedge clk);
        rd(4'd1, v); chk("R9", "ready seen", v[0], 1'b1);
        rd(4'd2, v); chk("R9", "not-busy event", v[0], 1'b1);

        // R12 self-clearing reset bit
        wr(4'd9, 10'h001);
        for (int i = 0; i <= 4; i++) begin
            if (i > 0) @(negedge clk);
            rd(4'd9, v);
            chk("R12", "reset bit", v[0], (i < 4) ? 1'b1 : 1'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule